// File: doc/BRIEF.md
# Two-Way Set Associative Write-Back Byte Cache

This block is a data cache between a processor that reads and writes single bytes and a main memory that moves whole 4-byte blocks. A 24-bit byte address is split into a tag, a set index and a byte offset. The set index selects one set of two lines, and both stored tags of that set are compared at once. A block may live in either line of its own set and nowhere else.

Writes stay in the cache and mark the line dirty. Memory is written only when a dirty line is chosen as the victim, and that write always happens before the missing block is fetched. The victim is picked in this order: an empty way first, then the way that was not touched most recently. A single recency flag per set tracks that choice. A write miss fetches the block first, then merges the byte into it.

The number of sets is a parameter. A 13-bit set field gives the full-size cache; the default is a small one. While a miss is being served, the processor side sees ready low.

Top module: `cache2w_top`

## Requirements
- R1: After reset, `cpu_ready` and `mem_req` are low, and every line is invalid, so the first access to any address misses.
- R2: The address offset is bits [1:0] and the set index is the next SET_BITS bits; the tag is the rest. `mem_addr` carries the block address, the byte address without its offset. For example, byte address 0x16339C is fetched as block 0x058CE7.
- R3: A request whose tag matches a valid way of its set is a hit. `cpu_ready` is high in the cycle right after the accepting edge, and no memory request is made.
- R4: A read returns the byte at its offset in little-endian lane order: offset 0 is bits [7:0] of the block word.
- R5: A write hit changes only the cached byte and marks the line dirty. No memory write is issued.
- R6: A miss whose victim is invalid or clean issues a single read of the requested block and no memory write.
- R7: A miss whose victim is dirty first writes the victim's block, at the victim's own block address, to memory. Only after that write is acknowledged is the requested block read.
- R8: The victim is way 0 if way 0 is invalid, else way 1 if way 1 is invalid. Otherwise it is the way not used most recently, where both hits and fills count as use. At most one way of a set matches any tag.
- R9: A write miss allocates the line: the block is read, the byte is merged in, and the line is stored dirty.
- R10: `cpu_ready` is high for one cycle per request. A memory request holds its address and direction steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request strobe, taken when the cache is idle |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 8 | Byte to write |
| cpu_rdata | output | 8 | Byte returned, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory block request, held until acknowledged |
| mem_we | output | 1 | 1 = write back a block, 0 = read a block |
| mem_addr | output | 22 | Block address (tag and set) |
| mem_wdata | output | 32 | Block written back |
| mem_rdata | input | 32 | Block read, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge from memory |

## Verification
Several protocol rules are checked on every cycle. These are the one-cycle hit response, the ready pulse shape, and a memory request staying steady until it is acknowledged. They also include a dirty miss always starting with a write and a clean miss starting with a read, a write-back always being followed by a fetch, and never two ways matching one tag. Other behaviour needs the bench's scenarios and its model of the cache. This covers which way is evicted after a given history of use, the byte values read back, the merge on a write miss, and the block address and contents reaching memory on eviction.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FETCH = 2'd2,
    ST_RESP  = 2'd3
  } cstate_e;

  // Read one byte lane of a block word; lane 0 is the low byte.
  function automatic logic [7:0] lane_get(input logic [31:0] word, input logic [1:0] off);
    return word[{3'd0, off} * 5'd8 +: 8];
  endfunction

  // Replace one byte lane of a block word.
  function automatic logic [31:0] lane_put(input logic [31:0] word, input logic [1:0] off,
                                           input logic [7:0] val);
    logic [31:0] res;
    res = word;
    res[{3'd0, off} * 5'd8 +: 8] = val;
    return res;
  endfunction

endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int SET_BITS = 4,
  parameter int TAG_W    = 18,
  parameter int LINE_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] rd_set,
  output logic                rd_valid,
  output logic                rd_dirty,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [LINE_W-1:0]   rd_data,
  input  logic                wr_en,
  input  logic [SET_BITS-1:0] wr_set,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [LINE_W-1:0]   wr_data,
  input  logic                wr_dirty
);
  localparam int SETS = 1 << SET_BITS;

  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   dirty_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_set] <= 1'b1;
      dirty_q[wr_set] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set]  <= wr_tag;
      data_q[wr_set] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_set];
  assign rd_dirty = dirty_q[rd_set];
  assign rd_tag   = tag_q[rd_set];
  assign rd_data  = data_q[rd_set];
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int SET_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] rd_set,
  output logic                rd_way0_recent,
  input  logic                touch_en,
  input  logic [SET_BITS-1:0] touch_set,
  input  logic                touch_way
);
  localparam int SETS = 1 << SET_BITS;

  // One flag per set: 1 means way 0 was used last, so way 1 is the eviction choice.
  logic [SETS-1:0] recent_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        recent_q <= '0;
    else if (touch_en) recent_q[touch_set] <= (touch_way == 1'b0);
  end

  assign rd_way0_recent = recent_q[rd_set];
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
  import cache2w_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SET_BITS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_req,
  input  logic                       cpu_we,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [7:0]                 cpu_wdata,
  output logic [7:0]                 cpu_rdata,
  output logic                       cpu_ready,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [ADDR_W-3:0]          mem_addr,
  output logic [31:0]                mem_wdata,
  input  logic [31:0]                mem_rdata,
  input  logic                       mem_ack
);
  localparam int OFF_W = 2;
  localparam int TAG_W = ADDR_W - SET_BITS - OFF_W;
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int WAYS  = 2;

  cstate_e st_q, st_d;
  logic [ADDR_W-1:0] q_addr;
  logic              q_we;
  logic [7:0]        q_wdata;
  logic              q_victim;
  logic [7:0]        rdata_q;

  // Lookup fields: live request while idle, held request otherwise.
  logic                is_idle;
  logic [ADDR_W-1:0]   look_addr;
  logic                look_we;
  logic [7:0]          look_wdata;
  logic [OFF_W-1:0]    look_off;
  logic [SET_BITS-1:0] look_set;
  logic [TAG_W-1:0]    look_tag;

  assign is_idle    = (st_q == ST_IDLE);
  assign look_addr  = is_idle ? cpu_addr  : q_addr;
  assign look_we    = is_idle ? cpu_we    : q_we;
  assign look_wdata = is_idle ? cpu_wdata : q_wdata;
  assign look_off   = look_addr[OFF_W-1:0];
  assign look_set   = look_addr[OFF_W +: SET_BITS];
  assign look_tag   = look_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]  w_valid, w_dirty, w_wr_en, hit_vec;
  logic [TAG_W-1:0] w_tag  [WAYS];
  logic [31:0]      w_data [WAYS];
  logic [31:0]      wr_data;
  logic             wr_dirty, wr_any, wr_sel_way;
  logic             way0_recent, pick_victim, vic_dirty;
  logic             hit_any, hit_way;

  // Named events used by the checker.
  logic acc_start, acc_hit, acc_miss, wb_done, fill_done;

  assign hit_any     = |hit_vec;
  assign hit_way     = hit_vec[1];
  assign pick_victim = !w_valid[0] ? 1'b0 : (!w_valid[1] ? 1'b1 : way0_recent);
  assign vic_dirty   = w_dirty[pick_victim];

  assign acc_start = is_idle && cpu_req;
  assign acc_hit   = acc_start && hit_any;
  assign acc_miss  = acc_start && !hit_any;
  assign wb_done   = (st_q == ST_WBACK) && mem_ack;
  assign fill_done = (st_q == ST_FETCH) && mem_ack;

  assign wr_any     = (acc_hit && look_we) || fill_done;
  assign wr_sel_way = fill_done ? q_victim : hit_way;
  assign wr_dirty   = fill_done ? q_we : 1'b1;
  assign wr_data    = fill_done ? (q_we ? lane_put(mem_rdata, look_off, q_wdata) : mem_rdata)
                                : lane_put(w_data[hit_way], look_off, look_wdata);

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    localparam logic WAY_ID = 1'(g);
    assign hit_vec[g] = w_valid[g] && (w_tag[g] == look_tag);
    assign w_wr_en[g] = wr_any && (wr_sel_way == WAY_ID);
    cache2w_way #(.SET_BITS(SET_BITS), .TAG_W(TAG_W), .LINE_W(32)) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (look_set),
      .rd_valid (w_valid[g]),
      .rd_dirty (w_dirty[g]),
      .rd_tag   (w_tag[g]),
      .rd_data  (w_data[g]),
      .wr_en    (w_wr_en[g]),
      .wr_set   (look_set),
      .wr_tag   (look_tag),
      .wr_data  (wr_data),
      .wr_dirty (wr_dirty)
    );
  end

  cache2w_lru #(.SET_BITS(SET_BITS)) u_lru (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_set         (look_set),
    .rd_way0_recent (way0_recent),
    .touch_en       (acc_hit || fill_done),
    .touch_set      (look_set),
    .touch_way      (wr_sel_way)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (acc_hit) st_d = ST_RESP;
                else if (acc_miss) st_d = vic_dirty ? ST_WBACK : ST_FETCH;
      ST_WBACK: if (wb_done) st_d = ST_FETCH;
      ST_FETCH: if (fill_done) st_d = ST_RESP;
      ST_RESP:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      q_addr   <= '0;
      q_we     <= 1'b0;
      q_wdata  <= '0;
      q_victim <= 1'b0;
      rdata_q  <= '0;
    end else begin
      st_q <= st_d;
      if (acc_start) begin
        q_addr   <= cpu_addr;
        q_we     <= cpu_we;
        q_wdata  <= cpu_wdata;
        q_victim <= pick_victim;
      end
      if (acc_hit)
        rdata_q <= look_we ? look_wdata : lane_get(w_data[hit_way], look_off);
      else if (fill_done)
        rdata_q <= q_we ? q_wdata : lane_get(mem_rdata, look_off);
    end
  end

  assign cpu_rdata = rdata_q;
  assign cpu_ready = (st_q == ST_RESP);
  assign mem_req   = (st_q == ST_WBACK) || (st_q == ST_FETCH);
  assign mem_we    = (st_q == ST_WBACK);
  assign mem_addr  = mem_we ? BLK_W'({w_tag[q_victim], look_set}) : BLK_W'({look_tag, look_set});
  assign mem_wdata = w_data[q_victim];
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int BLK_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_ready,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [BLK_W-1:0] mem_addr,
  input logic             acc_hit,
  input logic             acc_miss,
  input logic             vic_dirty,
  input logic [1:0]       hit_vec
);
  a_r3_hit_ready: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> (cpu_ready && !mem_req));

  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r7_wb_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  a_r7_dirty_writes_first: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_miss && vic_dirty) |=> (mem_req && mem_we));

  a_r6_clean_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_miss && !vic_dirty) |=> (mem_req && !mem_we));

  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

bind cache2w_top cache2w_chk #(.BLK_W(BLK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ready (cpu_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .acc_hit   (acc_hit),
  .acc_miss  (acc_miss),
  .vic_dirty (vic_dirty),
  .hit_vec   (hit_vec)
);

// File: tb/cache2w_top_bench.sv
module cache2w_top_bench;
  localparam int SB   = 4;
  localparam int NS   = 1 << SB;
  localparam int TW   = 24 - SB - 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_ready, mem_req, mem_we;
  logic [21:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #10 clk = ~clk;

  cache2w_top #(.ADDR_W(24), .SET_BITS(SB)) u_cache2w_top (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bench memory: acknowledges every request on its second waiting cycle.
  logic [31:0] bmem [int];
  int          mcnt = 0;
  int          wr_addr_q [$];
  int          rd_addr_q [$];

  function automatic logic [31:0] init_word(input int blk);
    return (blk * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      mcnt = 0;
    end else if (mem_req) begin
      mcnt++;
      if (mcnt == 2) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          bmem[int'(mem_addr)] = mem_wdata;
          wr_addr_q.push_back(int'(mem_addr));
        end else begin
          mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : init_word(int'(mem_addr));
          rd_addr_q.push_back(int'(mem_addr));
        end
      end
    end
  end

  // Behavioural reference of cache contents and of what memory should hold.
  bit          mv   [NS][2];
  bit          md   [NS][2];
  int          mtg  [NS][2];
  logic [31:0] mdat [NS][2];
  bit          mw0_last [NS];
  logic [31:0] emem [int];

  task automatic do_op(input bit we, input logic [23:0] a, input logic [7:0] wd, input string lbl);
    int s, t, o, w, blk, lat, exp_lat;
    bit hit, wb;
    int wb_blk;
    logic [31:0] wb_word, line;
    logic [7:0] exp_byte;
    s = int'(a[2 +: SB]); t = int'(a[23 -: TW]); o = int'(a[1:0]); blk = int'(a[23:2]);
    hit = 0; wb = 0; w = 0; wb_blk = 0; wb_word = '0;
    for (int k = 0; k < 2; k++) if (mv[s][k] && mtg[s][k] == t) begin hit = 1; w = k; end
    if (!hit) begin
      if (!mv[s][0]) w = 0; else if (!mv[s][1]) w = 1; else w = mw0_last[s] ? 1 : 0;
      if (mv[s][w] && md[s][w]) begin
        wb = 1; wb_blk = (mtg[s][w] << SB) | s; wb_word = mdat[s][w];
        emem[wb_blk] = wb_word;
      end
      mdat[s][w] = emem.exists(blk) ? emem[blk] : init_word(blk);
      mv[s][w] = 1; mtg[s][w] = t; md[s][w] = 0;
    end
    line = mdat[s][w];
    exp_byte = line[o*8 +: 8];
    if (we) begin
      line[o*8 +: 8] = wd; mdat[s][w] = line; md[s][w] = 1; exp_byte = wd;
    end
    mw0_last[s] = (w == 0);
    exp_lat = hit ? 1 : (wb ? 6 : 3);
    wr_addr_q.delete(); rd_addr_q.delete();

    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    lat = 1;
    while (!cpu_ready && lat < 40) begin @(negedge clk); lat++; end
    if (hit)     chk(lat == exp_lat, "R3", {lbl, " hit latency"}, lat, exp_lat);
    else if (wb) chk(lat == exp_lat, "R7", {lbl, " dirty-miss latency"}, lat, exp_lat);
    else         chk(lat == exp_lat, "R6", {lbl, " clean-miss latency"}, lat, exp_lat);
    if (we) chk(cpu_rdata == wd, "R9", {lbl, " write byte echo"}, cpu_rdata, wd);
    else    chk(cpu_rdata == exp_byte, "R4", {lbl, " read byte"}, cpu_rdata, exp_byte);
    if (wb) begin
      chk(wr_addr_q.size() == 1 && wr_addr_q[0] == wb_blk, "R7", {lbl, " write-back block"},
          wr_addr_q.size() > 0 ? wr_addr_q[0] : -1, wb_blk);
      chk(bmem[wb_blk] == wb_word, "R7", {lbl, " write-back data"}, bmem[wb_blk], wb_word);
    end else begin
      chk(wr_addr_q.size() == 0, "R5", {lbl, " no memory write"}, wr_addr_q.size(), 0);
    end
    if (!hit) chk(rd_addr_q.size() == 1 && rd_addr_q[0] == blk, "R2", {lbl, " fetched block"},
                  rd_addr_q.size() > 0 ? rd_addr_q[0] : -1, blk);
    else      chk(rd_addr_q.size() == 0, "R3", {lbl, " no fetch on hit"}, rd_addr_q.size(), 0);
    @(negedge clk);
    chk(!cpu_ready, "R10", {lbl, " ready is a single pulse"}, cpu_ready, 0);
  endtask

  function automatic logic [23:0] mk(input int t, input int s, input int o);
    return {TW'(t), SB'(s), 2'(o)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cpu_ready == 1'b0, "R1", "ready low after reset", cpu_ready, 0);
    chk(mem_req == 1'b0, "R1", "no memory request after reset", mem_req, 0);
    rst_n = 1'b1;

    // R1/R2: first access misses; worked address fetched as its block number
    do_op(0, 24'h16339C, 8'h00, "R1 R2 worked address");
    chk(24'h16339C >> 2 == 22'h058CE7, "R2", "block number of worked address", 24'h16339C >> 2, 22'h058CE7);
    do_op(0, mk(1, 5, 0), 8'h00, "R1 cold");
    do_op(0, mk(1, 5, 3), 8'h00, "R3 R4 hit lane 3");
    do_op(1, mk(1, 5, 2), 8'hA5, "R5 write hit");
    do_op(0, mk(2, 5, 1), 8'h00, "R8 second way");
    do_op(0, mk(1, 5, 2), 8'h00, "R5 read back");
    do_op(0, mk(3, 5, 0), 8'h00, "R8 evict lru way1");
    do_op(0, mk(1, 5, 0), 8'h00, "R8 way0 kept");
    do_op(0, mk(2, 5, 0), 8'h00, "R8 evict tag3");
    do_op(0, mk(4, 5, 0), 8'h00, "R7 dirty eviction");
    do_op(1, mk(7, 9, 1), 8'h3C, "R9 write miss");
    do_op(0, mk(7, 9, 1), 8'h00, "R9 merged byte");
    do_op(0, mk(7, 9, 0), 8'h00, "R9 untouched lane");
    do_op(0, mk(8, 9, 0), 8'h00, "R9 fill other way");
    do_op(0, mk(9, 9, 0), 8'h00, "R9 R7 merged write-back");

    for (int i = 0; i < 400; i++) begin
      do_op(1'($urandom_range(0, 1)), mk($urandom_range(0, 5), $urandom_range(0, 3),
            $urandom_range(0, 3)), 8'($urandom), "R8 mixed");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule